// File: doc/BRIEF.md
# DSP Data Register File

This block is the operand store of a floating-point DSP data path. It keeps ten 96-bit data registers: eight general-purpose registers (indices 0 to 7) that every operation treats the same way, and two auxiliary registers (indices 8 and 9) with narrower permitted roles. The registers sit between two data buses and the multiply and add units. Two bus write ports load operands. Two bus read ports drive any register back onto either bus for save, restore or delayed memory writes. Two operand read ports feed the arithmetic units, and one result write port takes their output.

An upstream decoder, which is not part of this block, supplies an operation class and register selects. The block checks each cycle's access pattern. Using an auxiliary register as an adder source, writing an arithmetic result to one, or selecting an index outside 0 to 9 raises a combinational illegal-access flag, and that cycle commits no write at all. When two writers aim at the same register, a fixed priority picks the winner and a conflict flag is raised. All reads return the contents held before the clock edge, so a register can be reloaded for the next instruction in the same cycle the current instruction reads it.

Top module: `dsp_data_regfile`

## Requirements
- R1: After reset, all ten registers read as zero on both bus read ports, and both flags are low.
- R2: A bus write enable with a select of 0 to 9 stores that port's data in the selected register at the next rising clock edge. The stored value is then readable on both bus read ports and on both operand ports.
- R3: The operation class encoding is 0 = none, 1 = multiply, 2 = add, 3 = reserved (treated as none). With class multiply, sources 0 to 9 are all legal and the operand ports return the selected contents.
- R4: With class add, an operand select of 8 or 9 raises illegalFlag in the same cycle. Add operands drawn from 0 to 7 do not raise it.
- R5: A result write to register 8 or 9 raises illegalFlag and leaves that register unchanged.
- R6: When a result write and a bus write select the same register in one cycle, the result is stored and conflictFlag is high in that cycle.
- R7: When both bus write ports select the same register in one cycle, the data from bus Y is stored and conflictFlag is high in that cycle.
- R8: A read in the same cycle as a write to the same register returns the old contents. The new contents appear from the next cycle onward.
- R9: Writes from bus X, bus Y and the result port to three distinct registers all commit in the same cycle.
- R10: In any cycle with illegalFlag high, no register changes, including registers targeted by otherwise legal writes in that cycle.
- R11: An enabled write select or an active-operation source select of 10 or more raises illegalFlag. A read select of 10 or more returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low, clears all registers |
| opClass | input | 2 | Operation class: 0 none, 1 multiply, 2 add, 3 reserved |
| srcASel | input | 4 | Operand A register select |
| srcBSel | input | 4 | Operand B register select |
| opA | output | DATA_W | Operand A contents |
| opB | output | DATA_W | Operand B contents |
| resWrEn | input | 1 | Arithmetic result write enable |
| resSel | input | 4 | Result destination select |
| resData | input | DATA_W | Arithmetic result value |
| busXWrEn | input | 1 | Bus X load enable |
| busXWrSel | input | 4 | Bus X load destination |
| busXWrData | input | DATA_W | Bus X load value |
| busYWrEn | input | 1 | Bus Y load enable |
| busYWrSel | input | 4 | Bus Y load destination |
| busYWrData | input | DATA_W | Bus Y load value |
| busXRdSel | input | 4 | Register driven onto bus X |
| busXRdData | output | DATA_W | Bus X read value |
| busYRdSel | input | 4 | Register driven onto bus Y |
| busYRdData | output | DATA_W | Bus Y read value |
| illegalFlag | output | 1 | Illegal access in the current cycle; no write commits |
| conflictFlag | output | 1 | Two writers target the same register this cycle |

## Verification
The assertions assume that enables, selects and the operation class are known values at every rising edge after reset. They also assume that the write data is held steady through the sampling edge, because the load checks compare the stored register with the previous cycle's data. The stimulus changes every input only on the falling edge and returns all enables to zero between scenarios, so each property sees one clean access pattern per cycle. Out-of-range selects are driven only in the scenario that exercises them.

// File: rtl/dsp_rf_pkg.sv
package dsp_rf_pkg;
  localparam int GP_REGS  = 8;
  localparam int AUX_REGS = 2;
  localparam int NUM_REGS = GP_REGS + AUX_REGS;
  localparam int SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MUL  = 2'd1,
    OP_ADD  = 2'd2,
    OP_RSVD = 2'd3
  } opClass_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] loadEn;
    logic [NUM_REGS-1:0] takeRes;
    logic [NUM_REGS-1:0] takeY;
  } wrStrobe_t;
endpackage

// File: rtl/dsp_rf_ctrl.sv
module dsp_rf_ctrl
  import dsp_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opClassIn,
  input  logic [SEL_W-1:0] srcASel,
  input  logic [SEL_W-1:0] srcBSel,
  input  logic             resWrEn,
  input  logic [SEL_W-1:0] resSel,
  input  logic             busXWrEn,
  input  logic [SEL_W-1:0] busXWrSel,
  input  logic             busYWrEn,
  input  logic [SEL_W-1:0] busYWrSel,
  output wrStrobe_t        strb,
  output logic             illegal,
  output logic             conflict
);
  localparam logic [SEL_W-1:0] GP_SEL  = SEL_W'(GP_REGS);
  localparam logic [SEL_W-1:0] NUM_SEL = SEL_W'(NUM_REGS);

  opClass_e op;
  logic opActive, addAux, srcRange, resAux, wrRange;
  logic [NUM_REGS-1:0] hitX, hitY, hitR, multi;

  assign op = opClass_e'(opClassIn);

  always_comb begin
    opActive = (op == OP_MUL) || (op == OP_ADD);
    addAux   = (op == OP_ADD) && ((srcASel >= GP_SEL) || (srcBSel >= GP_SEL));
    srcRange = opActive && ((srcASel >= NUM_SEL) || (srcBSel >= NUM_SEL));
    resAux   = resWrEn && (resSel >= GP_SEL);
    wrRange  = (busXWrEn && (busXWrSel >= NUM_SEL)) ||
               (busYWrEn && (busYWrSel >= NUM_SEL));
    illegal  = addAux || srcRange || resAux || wrRange;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hitX[i]  = busXWrEn && (busXWrSel == SEL_W'(i));
    assign hitY[i]  = busYWrEn && (busYWrSel == SEL_W'(i));
    assign hitR[i]  = resWrEn  && (resSel    == SEL_W'(i));
    assign multi[i] = (hitX[i] & hitY[i]) | (hitX[i] & hitR[i]) | (hitY[i] & hitR[i]);
  end

  assign conflict     = |multi;
  assign strb.loadEn  = illegal ? '0 : (hitX | hitY | hitR);
  assign strb.takeRes = hitR;
  assign strb.takeY   = hitY;

  // R5
  aux_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(strb.loadEn[NUM_REGS-1:GP_REGS] & strb.takeRes[NUM_REGS-1:GP_REGS])));

  // R4
  add_aux_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opClassIn == 2'd2 && srcASel >= GP_SEL) |-> (illegal && strb.loadEn == '0));

  // R6
  res_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resWrEn && busXWrEn && resSel == busXWrSel) |-> conflict);
endmodule

// File: rtl/dsp_rf_dp.sv
module dsp_rf_dp
  import dsp_rf_pkg::*;
#(
  parameter int DATA_W = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [DATA_W-1:0] busXWrData,
  input  logic [DATA_W-1:0] busYWrData,
  input  logic [DATA_W-1:0] resData,
  input  logic [SEL_W-1:0]  srcASel,
  input  logic [SEL_W-1:0]  srcBSel,
  input  logic [SEL_W-1:0]  busXRdSel,
  input  logic [SEL_W-1:0]  busYRdSel,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] busXRdData,
  output logic [DATA_W-1:0] busYRdData
);
  localparam int RD_PORTS = 4;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [RD_PORTS-1:0][SEL_W-1:0]  rdSel;
  logic [RD_PORTS-1:0][DATA_W-1:0] rdData;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regs[i] <= '0;
      else if (strb.loadEn[i])
        regs[i] <= strb.takeRes[i] ? resData :
                   (strb.takeY[i] ? busYWrData : busXWrData);
    end

    // R6
    res_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadEn[i] && strb.takeRes[i]) |=> (regs[i] == $past(resData)));

    // R7
    y_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadEn[i] && !strb.takeRes[i] && strb.takeY[i]) |=> (regs[i] == $past(busYWrData)));
  end

  assign rdSel = {busYRdSel, busXRdSel, srcBSel, srcASel};

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_comb begin
      rdData[p] = '0;
      for (int k = 0; k < NUM_REGS; k++)
        if (rdSel[p] == SEL_W'(k)) rdData[p] = regs[k];
    end
  end

  assign opA        = rdData[0];
  assign opB        = rdData[1];
  assign busXRdData = rdData[2];
  assign busYRdData = rdData[3];

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn == '0) |=> $stable(regs));
endmodule

// File: rtl/dsp_data_regfile.sv
module dsp_data_regfile
  import dsp_rf_pkg::*;
#(
  parameter int DATA_W = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opClass,
  input  logic [3:0]        srcASel,
  input  logic [3:0]        srcBSel,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  input  logic              resWrEn,
  input  logic [3:0]        resSel,
  input  logic [DATA_W-1:0] resData,
  input  logic              busXWrEn,
  input  logic [3:0]        busXWrSel,
  input  logic [DATA_W-1:0] busXWrData,
  input  logic              busYWrEn,
  input  logic [3:0]        busYWrSel,
  input  logic [DATA_W-1:0] busYWrData,
  input  logic [3:0]        busXRdSel,
  output logic [DATA_W-1:0] busXRdData,
  input  logic [3:0]        busYRdSel,
  output logic [DATA_W-1:0] busYRdData,
  output logic              illegalFlag,
  output logic              conflictFlag
);
  wrStrobe_t strb;

  dsp_rf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opClassIn(opClass),
    .srcASel(srcASel), .srcBSel(srcBSel),
    .resWrEn(resWrEn), .resSel(resSel),
    .busXWrEn(busXWrEn), .busXWrSel(busXWrSel),
    .busYWrEn(busYWrEn), .busYWrSel(busYWrSel),
    .strb(strb), .illegal(illegalFlag), .conflict(conflictFlag)
  );

  dsp_rf_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busXWrData(busXWrData), .busYWrData(busYWrData), .resData(resData),
    .srcASel(srcASel), .srcBSel(srcBSel),
    .busXRdSel(busXRdSel), .busYRdSel(busYRdSel),
    .opA(opA), .opB(opB), .busXRdData(busXRdData), .busYRdData(busYRdData)
  );
endmodule

// File: tb/dsp_data_regfile_tb_top.sv
module dsp_data_regfile_tb_top;
  localparam int DW = 96;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] opClass;
  logic [3:0] srcASel, srcBSel, resSel, busXWrSel, busYWrSel, busXRdSel, busYRdSel;
  logic resWrEn, busXWrEn, busYWrEn;
  logic [DW-1:0] resData, busXWrData, busYWrData;
  logic [DW-1:0] opA, opB, busXRdData, busYRdData;
  logic illegalFlag, conflictFlag;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] mdl [10];

  always #5 clk = ~clk;

  dsp_data_regfile #(.DATA_W(DW)) dut_i (.*);

  function automatic logic [DW-1:0] pat(int i, int k);
    return {32'(k) * 32'h0101_0101 ^ 32'hA5A5_0000, 32'(i) + 32'h1000, ~(32'(i * 7 + k))};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkBit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    opClass = 2'd0; srcASel = 4'd0; srcBSel = 4'd0;
    resWrEn = 1'b0; resSel = 4'd0; resData = '0;
    busXWrEn = 1'b0; busXWrSel = 4'd0; busXWrData = '0;
    busYWrEn = 1'b0; busYWrSel = 4'd0; busYWrData = '0;
    busXRdSel = 4'd0; busYRdSel = 4'd0;
  endtask

  // compare every register with the model over all four read ports
  task automatic checkAll(string tag);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      clearIn();
      busXRdSel = 4'(i); busYRdSel = 4'(i); srcASel = 4'(i); srcBSel = 4'(9 - i);
      #1;
      chk({tag, " busX"}, busXRdData, mdl[i]);
      chk({tag, " busY"}, busYRdData, mdl[i]);
      chk({tag, " opA"}, opA, mdl[i]);
      chk({tag, " opB"}, opB, mdl[9 - i]);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 10; i++) mdl[i] = '0;
    @(negedge clk); #1;
    chkBit("R1 illegal after reset", illegalFlag, 1'b0);
    chkBit("R1 conflict after reset", conflictFlag, 1'b0);
    checkAll("R1 reset");
  endtask

  task automatic t_busLoad();
    for (int i = 0; i < 10; i += 2) begin
      @(negedge clk);
      clearIn();
      busXWrEn = 1'b1; busXWrSel = 4'(i);     busXWrData = pat(i, 1);
      busYWrEn = 1'b1; busYWrSel = 4'(i + 1); busYWrData = pat(i + 1, 1);
      #1;
      chkBit("R2 no illegal", illegalFlag, 1'b0);
      chkBit("R9 no conflict", conflictFlag, 1'b0);
      @(posedge clk);
      mdl[i] = pat(i, 1); mdl[i + 1] = pat(i + 1, 1);
    end
    checkAll("R2 load");
  endtask

  task automatic t_threeWay();
    @(negedge clk);
    clearIn();
    busXWrEn = 1'b1; busXWrSel = 4'd1; busXWrData = pat(1, 5);
    busYWrEn = 1'b1; busYWrSel = 4'd2; busYWrData = pat(2, 5);
    resWrEn = 1'b1;  resSel = 4'd4;    resData = pat(4, 5);
    opClass = 2'd1;  srcASel = 4'd1;   srcBSel = 4'd4;
    #1;
    chkBit("R9 three-way legal", illegalFlag, 1'b0);
    chkBit("R9 three-way no conflict", conflictFlag, 1'b0);
    @(posedge clk);
    mdl[1] = pat(1, 5); mdl[2] = pat(2, 5); mdl[4] = pat(4, 5);
    checkAll("R9 three-way");
  endtask

  task automatic t_rbw();
    @(negedge clk);
    clearIn();
    busXWrEn = 1'b1; busXWrSel = 4'd3; busXWrData = pat(3, 9);
    srcASel = 4'd3; busYRdSel = 4'd3; opClass = 2'd2;
    #1;
    chk("R8 opA old value", opA, mdl[3]);
    chk("R8 busY old value", busYRdData, mdl[3]);
    @(posedge clk);
    mdl[3] = pat(3, 9);
    @(negedge clk);
    clearIn();
    srcASel = 4'd3; busYRdSel = 4'd3;
    #1;
    chk("R8 opA new value", opA, mdl[3]);
    chk("R8 busY new value", busYRdData, mdl[3]);
  endtask

  task automatic t_mulAux();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      clearIn();
      opClass = 2'(c); srcASel = 4'd8; srcBSel = 4'd9;
      #1;
      chkBit((c == 2) ? "R4 add aux illegal" : "R3 aux source legal", illegalFlag, c == 2);
      chk("R3 opA aux", opA, mdl[8]);
      chk("R3 opB aux", opB, mdl[9]);
    end
    @(negedge clk);
    clearIn();
    opClass = 2'd2; srcASel = 4'd0; srcBSel = 4'd7;
    #1;
    chkBit("R4 add gp legal", illegalFlag, 1'b0);
  endtask

  task automatic t_addAuxBlock();
    @(negedge clk);
    clearIn();
    opClass = 2'd2; srcASel = 4'd5; srcBSel = 4'd9;
    busXWrEn = 1'b1; busXWrSel = 4'd1; busXWrData = pat(1, 20);
    resWrEn = 1'b1;  resSel = 4'd0;    resData = pat(0, 20);
    #1;
    chkBit("R4 add srcB aux illegal", illegalFlag, 1'b1);
    @(posedge clk);
    checkAll("R10 blocked writes");
  endtask

  task automatic t_resAux();
    for (int r = 8; r < 10; r++) begin
      @(negedge clk);
      clearIn();
      opClass = 2'd1;
      resWrEn = 1'b1; resSel = 4'(r); resData = pat(r, 30);
      #1;
      chkBit("R5 result to aux illegal", illegalFlag, 1'b1);
      @(posedge clk);
      @(negedge clk);
      clearIn();
      busXRdSel = 4'(r);
      #1;
      chk("R5 aux unchanged", busXRdData, mdl[r]);
    end
  endtask

  task automatic t_conflictRes();
    @(negedge clk);
    clearIn();
    resWrEn = 1'b1;  resSel = 4'd5;    resData = pat(5, 40);
    busXWrEn = 1'b1; busXWrSel = 4'd5; busXWrData = pat(5, 41);
    busYWrEn = 1'b1; busYWrSel = 4'd6; busYWrData = pat(6, 41);
    #1;
    chkBit("R6 conflict flag", conflictFlag, 1'b1);
    chkBit("R6 legal", illegalFlag, 1'b0);
    @(posedge clk);
    mdl[5] = pat(5, 40); mdl[6] = pat(6, 41);
    @(negedge clk);
    clearIn();
    busXRdSel = 4'd5; busYRdSel = 4'd6;
    #1;
    chk("R6 result wins", busXRdData, mdl[5]);
    chk("R6 other write kept", busYRdData, mdl[6]);
  endtask

  task automatic t_conflictXY();
    @(negedge clk);
    clearIn();
    busXWrEn = 1'b1; busXWrSel = 4'd9; busXWrData = pat(9, 50);
    busYWrEn = 1'b1; busYWrSel = 4'd9; busYWrData = pat(9, 51);
    #1;
    chkBit("R7 conflict flag", conflictFlag, 1'b1);
    @(posedge clk);
    mdl[9] = pat(9, 51);
    @(negedge clk);
    clearIn();
    busYRdSel = 4'd9;
    #1;
    chk("R7 bus Y wins", busYRdData, mdl[9]);
  endtask

  task automatic t_range();
    @(negedge clk);
    clearIn();
    busYWrEn = 1'b1; busYWrSel = 4'd12; busYWrData = pat(12, 60);
    busXWrEn = 1'b1; busXWrSel = 4'd7;  busXWrData = pat(7, 60);
    #1;
    chkBit("R11 write select range illegal", illegalFlag, 1'b1);
    @(posedge clk);
    @(negedge clk);
    clearIn();
    busXRdSel = 4'd7; busYRdSel = 4'd12; opClass = 2'd1; srcASel = 4'd15;
    #1;
    chk("R11 no write on range error", busXRdData, mdl[7]);
    chk("R11 read out of range zero", busYRdData, '0);
    chkBit("R11 source range illegal", illegalFlag, 1'b1);
  endtask

  initial begin
    clearIn();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_busLoad();
    t_threeWay();
    t_rbw();
    t_mulAux();
    t_addAuxBlock();
    t_resAux();
    t_conflictRes();
    t_conflictXY();
    t_range();
    checkAll("R2 final");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule